// File: doc/BRIEF.md
# I2C Master Command Sequencer

This block is the register-level front end of a single-bus I2C master. Software loads a byte into the data buffer and then writes a command word. Each bit of that word asks for one bus phase: begin a transfer by sending an address, send a data byte, receive a byte, receive the final byte, or end the transfer. The sequencer stores the requested bits as pending work. It then drives a byte-level bit engine one phase at a time, always in the same priority order. The engine does the actual SCL/SDA signalling. Each handshake stays open until the engine reports completion.

Every completed phase sets a flag in an interrupt status register, which software clears by writing 1s. An enable register masks the flags before they reach a registered interrupt line. The command register also returns a 4-bit phase code and the live bus-busy level. Bit 3 of the phase code is set whenever the bus is held by this master. A request to end the transfer while the bus is not held is reported as a protocol error, and no engine operation is issued for it.

Top module: `i2c_cmd_seq`

## Requirements
- R1: After reset, every readable register returns zero, the phase code is idle (0x0) and `irq` is low.
- R2: Register map (byte offsets): function control 0x00, timing A 0x04, timing B 0x08, interrupt enable 0x0C, status 0x10, command 0x14, data buffer 0x20; unmapped offsets read 0. Function control keeps only the bits in mask 0x0071C3FF, timing A keeps mask 0x0FFFFF0F, timing B keeps mask 0x7, interrupt enable keeps mask 0x7FFF, and a buffer write keeps only bits 7:0 (bits 15:8 become 0).
- R3: A command write is ignored unless function-control bit 0 (master enable) or bit 1 (slave enable) is set. Otherwise bits 15:0 of the write are ORed into the pending command bits, which read back in command bits 15:0. Command bit 0 = begin, 1 = send, 2 = slave send (stored only), 3 = receive, 4 = receive-last, 5 = end.
- R4: Begin issues engine op 0 with the buffer's low byte (address in bits 7:1, direction in bit 0). The phase code is 0x9 while the op runs, or 0xA if phase bit 3 was already set. On completion, ACK sets status bit 0 and NAK sets status bit 1. Both the begin and send bits are cleared, and the phase becomes 0x8.
- R5: Send issues engine op 1 with the buffer's low byte, and the phase code is 0xF while the op runs. ACK sets status bit 0 and NAK sets status bit 1. The send bit is cleared and the phase becomes 0x8.
- R6: Receive runs only if command bit 3 or bit 4 is pending and status bit 2 is clear. It issues engine op 2 with phase code 0xD, and `engNakLast` equals command bit 4. The received byte lands in buffer bits 15:8 and buffer bits 7:0 become 0. Status bit 2 is set, both receive bits are cleared, and the phase becomes 0x8.
- R7: End with phase bit 3 set issues engine op 3 with phase code 0xB and then sets status bit 4. End with phase bit 3 clear sets status bit 5 and issues no op. Either way the end bit is cleared and the phase becomes 0x0.
- R8: Pending work runs one engine op at a time in the order begin, send, receive, end. `engReq` and `engOp` stay steady until `engDone`.
- R9: Writing the status register clears each bit that is written as 1. If status bit 2 is cleared while a receive bit is still pending, the next receive starts without a further command write.
- R10: `irq` is the OR of status AND interrupt enable, delayed by one register stage.
- R11: Command register bit 16 reads the `engBusy` input, and bits 22:19 read the phase code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register byte offset for read and write |
| wdata | input | DATA_W | Write data |
| rdData | output | DATA_W | Combinational read data at `addr` |
| engReq | output | 1 | Engine operation request, held until done |
| engOp | output | 2 | Engine op: 0 begin, 1 send, 2 receive, 3 end |
| engByte | output | 8 | Address or data byte for the engine |
| engNakLast | output | 1 | Answer the received byte with NAK |
| engDone | input | 1 | Engine completion pulse |
| engAck | input | 1 | Peer acknowledged (valid with engDone) |
| engRxByte | input | 8 | Received byte (valid with engDone) |
| engBusy | input | 1 | Bus-busy level from the engine |
| irq | output | 1 | Registered interrupt |

## Verification
The bench builds the block with its default widths: a 6-bit byte offset and a 32-bit data word. These widths give the full register map and every mask bit, so the bench can write all-ones words and see exactly which bits each register keeps. A bench model of the engine answers after a fixed latency and logs each op. This lets a single command word that combines several requests be checked for its op order, the byte presented, and the receive-last flag. It also reaches the two corner cases that hinge on the phase code: the repeated begin from an active bus, and the end request from idle. The stalled receive that restarts when its status flag is cleared is reached the same way.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;
  localparam int REG_CTRL = 'h00;
  localparam int REG_TIMA = 'h04;
  localparam int REG_TIMB = 'h08;
  localparam int REG_IEN  = 'h0C;
  localparam int REG_STS  = 'h10;
  localparam int REG_CMD  = 'h14;
  localparam int REG_BUF  = 'h20;

  localparam logic [31:0] CTRL_MASK = 32'h0071_C3FF;
  localparam logic [31:0] TIMA_MASK = 32'h0FFF_FF0F;
  localparam logic [31:0] TIMB_MASK = 32'h0000_0007;

  localparam int STS_W = 15;
  localparam int CMD_W = 16;
  localparam int PEND_W = 6;

  localparam int C_BEGIN = 0;
  localparam int C_SEND  = 1;
  localparam int C_RECV  = 3;
  localparam int C_LAST  = 4;
  localparam int C_END   = 5;

  localparam int S_ACK  = 0;
  localparam int S_NAK  = 1;
  localparam int S_RXD  = 2;
  localparam int S_STOP = 4;
  localparam int S_ABN  = 5;

  localparam logic [3:0] PH_IDLE   = 4'h0;
  localparam logic [3:0] PH_ACTIVE = 4'h8;
  localparam logic [3:0] PH_BEGIN  = 4'h9;
  localparam logic [3:0] PH_REBGN  = 4'hA;
  localparam logic [3:0] PH_END    = 4'hB;
  localparam logic [3:0] PH_RECV   = 4'hD;
  localparam logic [3:0] PH_SEND   = 4'hF;

  typedef enum logic [1:0] {
    OP_BEGIN = 2'd0,
    OP_SEND  = 2'd1,
    OP_RECV  = 2'd2,
    OP_END   = 2'd3
  } engOp_t;

  typedef struct packed {
    logic [PEND_W-1:0] clrCmd;
    logic [STS_W-1:0]  setSts;
    logic              setPhase;
    logic [3:0]        phaseVal;
    logic              loadRx;
  } seqStrobe_t;
endpackage

// File: rtl/i2cseq_ctrl.sv
module i2cseq_ctrl
  import i2cseq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [PEND_W-1:0] pend,
  input  logic [3:0]        phase,
  input  logic              rxDone,
  input  logic              engDone,
  input  logic              engAck,
  output seqStrobe_t        strobe,
  output logic              engReq,
  output logic [1:0]        engOp,
  output logic              engNakLast
);
  logic   busyQ;
  engOp_t opQ;
  logic   nakQ;
  logic   launch;
  engOp_t nextOp;

  always_comb begin
    strobe = '0;
    launch = 1'b0;
    nextOp = OP_BEGIN;
    if (!busyQ) begin
      if (pend[C_BEGIN]) begin
        launch          = 1'b1;
        nextOp          = OP_BEGIN;
        strobe.setPhase = 1'b1;
        strobe.phaseVal = phase[3] ? PH_REBGN : PH_BEGIN;
      end else if (pend[C_SEND]) begin
        launch          = 1'b1;
        nextOp          = OP_SEND;
        strobe.setPhase = 1'b1;
        strobe.phaseVal = PH_SEND;
      end else if ((pend[C_RECV] || pend[C_LAST]) && !rxDone) begin
        launch          = 1'b1;
        nextOp          = OP_RECV;
        strobe.setPhase = 1'b1;
        strobe.phaseVal = PH_RECV;
      end else if (pend[C_END]) begin
        strobe.setPhase = 1'b1;
        if (phase[3]) begin
          launch          = 1'b1;
          nextOp          = OP_END;
          strobe.phaseVal = PH_END;
        end else begin
          strobe.setSts[S_ABN] = 1'b1;
          strobe.clrCmd[C_END] = 1'b1;
          strobe.phaseVal      = PH_IDLE;
        end
      end
    end else if (engDone) begin
      strobe.setPhase = 1'b1;
      strobe.phaseVal = PH_ACTIVE;
      case (opQ)
        OP_BEGIN: begin
          if (engAck) strobe.setSts[S_ACK] = 1'b1;
          else        strobe.setSts[S_NAK] = 1'b1;
          strobe.clrCmd[C_BEGIN] = 1'b1;
          strobe.clrCmd[C_SEND]  = 1'b1;
        end
        OP_SEND: begin
          if (engAck) strobe.setSts[S_ACK] = 1'b1;
          else        strobe.setSts[S_NAK] = 1'b1;
          strobe.clrCmd[C_SEND] = 1'b1;
        end
        OP_RECV: begin
          strobe.loadRx         = 1'b1;
          strobe.setSts[S_RXD]  = 1'b1;
          strobe.clrCmd[C_RECV] = 1'b1;
          strobe.clrCmd[C_LAST] = 1'b1;
        end
        default: begin
          strobe.setSts[S_STOP] = 1'b1;
          strobe.clrCmd[C_END]  = 1'b1;
          strobe.phaseVal       = PH_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      opQ   <= OP_BEGIN;
      nakQ  <= 1'b0;
    end else if (launch) begin
      busyQ <= 1'b1;
      opQ   <= nextOp;
      nakQ  <= pend[C_LAST];
    end else if (busyQ && engDone) begin
      busyQ <= 1'b0;
    end
  end

  assign engReq     = busyQ;
  assign engOp      = opQ;
  assign engNakLast = nakQ;
endmodule

// File: rtl/i2cseq_dp.sv
module i2cseq_dp
  import i2cseq_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdData,
  input  seqStrobe_t        strobe,
  input  logic [7:0]        rxByte,
  input  logic              engBusy,
  output logic [PEND_W-1:0] pend,
  output logic [3:0]        phase,
  output logic              rxDone,
  output logic [7:0]        txByte,
  output logic              irq
);
  logic [DATA_W-1:0] ctrlQ, timAQ, timBQ;
  logic [STS_W-1:0]  ienQ, stsQ;
  logic [CMD_W-1:0]  pendQ;
  logic [3:0]        phaseQ;
  logic [15:0]       bufQ;
  logic              irqQ;
  logic              hit [7];
  logic              cmdOk;
  logic [CMD_W-1:0]  clrWide;
  logic [STS_W-1:0]  stsClr;

  localparam int OFFS [7] = '{REG_CTRL, REG_TIMA, REG_TIMB, REG_IEN,
                              REG_STS, REG_CMD, REG_BUF};

  for (genvar g = 0; g < 7; g++) begin : g_dec
    assign hit[g] = wrEn && (addr == ADDR_W'(OFFS[g]));
  end

  assign cmdOk   = ctrlQ[0] | ctrlQ[1];
  assign clrWide = CMD_W'(strobe.clrCmd);
  assign stsClr  = hit[4] ? wdata[STS_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ  <= '0;
      timAQ  <= '0;
      timBQ  <= '0;
      ienQ   <= '0;
      stsQ   <= '0;
      pendQ  <= '0;
      phaseQ <= PH_IDLE;
      bufQ   <= '0;
      irqQ   <= 1'b0;
    end else begin
      if (hit[0]) ctrlQ <= wdata & DATA_W'(CTRL_MASK);
      if (hit[1]) timAQ <= wdata & DATA_W'(TIMA_MASK);
      if (hit[2]) timBQ <= wdata & DATA_W'(TIMB_MASK);
      if (hit[3]) ienQ  <= wdata[STS_W-1:0];
      stsQ  <= (stsQ & ~stsClr) | strobe.setSts;
      pendQ <= (pendQ & ~clrWide) |
               ((hit[5] && cmdOk) ? wdata[CMD_W-1:0] : '0);
      if (strobe.setPhase) phaseQ <= strobe.phaseVal;
      if (strobe.loadRx)   bufQ <= {rxByte, 8'h00};
      else if (hit[6])     bufQ <= {8'h00, wdata[7:0]};
      irqQ <= |(stsQ & ienQ);
    end
  end

  always_comb begin
    rdData = '0;
    case (addr)
      ADDR_W'(REG_CTRL): rdData = ctrlQ;
      ADDR_W'(REG_TIMA): rdData = timAQ;
      ADDR_W'(REG_TIMB): rdData = timBQ;
      ADDR_W'(REG_IEN):  rdData = DATA_W'(ienQ);
      ADDR_W'(REG_STS):  rdData = DATA_W'(stsQ);
      ADDR_W'(REG_CMD):  rdData = DATA_W'({phaseQ, 2'b00, engBusy, pendQ});
      ADDR_W'(REG_BUF):  rdData = DATA_W'(bufQ);
      default:           rdData = '0;
    endcase
  end

  assign pend   = pendQ[PEND_W-1:0];
  assign phase  = phaseQ;
  assign rxDone = stsQ[S_RXD];
  assign txByte = bufQ[7:0];
  assign irq    = irqQ;
endmodule

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq
  import i2cseq_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdData,
  output logic              engReq,
  output logic [1:0]        engOp,
  output logic [7:0]        engByte,
  output logic              engNakLast,
  input  logic              engDone,
  input  logic              engAck,
  input  logic [7:0]        engRxByte,
  input  logic              engBusy,
  output logic              irq
);
  seqStrobe_t        strobe;
  logic [PEND_W-1:0] pend;
  logic [3:0]        phase;
  logic              rxDone;

  i2cseq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .pend(pend), .phase(phase), .rxDone(rxDone),
    .engDone(engDone), .engAck(engAck), .strobe(strobe),
    .engReq(engReq), .engOp(engOp), .engNakLast(engNakLast)
  );

  i2cseq_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wdata(wdata),
    .rdData(rdData), .strobe(strobe), .rxByte(engRxByte),
    .engBusy(engBusy), .pend(pend), .phase(phase), .rxDone(rxDone),
    .txByte(engByte), .irq(irq)
  );
endmodule

// File: rtl/i2c_cmd_seq_chk.sv
module i2c_cmd_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       engReq,
  input logic [1:0] engOp,
  input logic       engDone,
  input logic [3:0] phase,
  input logic       rxDone
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    engReq && !engDone |=> engReq); // R8
  AST_OP_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    engReq && !engDone |=> $stable(engOp)); // R8
  AST_REQ_ON_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    engReq |-> phase[3]); // R4
  AST_RECV_GUARD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(engReq) && engOp == 2'd2 |-> !$past(rxDone)); // R6
  AST_END_CODE: assert property (@(posedge clk) disable iff (!rstN)
    engReq && engOp == 2'd3 |-> phase == 4'hB); // R7
  AST_END_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    engReq && engDone && engOp == 2'd3 |=> phase == 4'h0); // R7
endmodule

bind i2c_cmd_seq i2c_cmd_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .engReq(engReq), .engOp(engOp),
  .engDone(engDone), .phase(phase), .rxDone(rxDone)
);

// File: tb/tb_i2c_cmd_seq.sv
module tb_i2c_cmd_seq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdData;
  logic        engReq, engNakLast, irq;
  logic [1:0]  engOp;
  logic [7:0]  engByte;
  logic        engDone = 1'b0, engAck = 1'b0, engBusy = 1'b0;
  logic [7:0]  engRxByte = '0;

  int checks = 0;
  int failures = 0;
  logic        ackVal = 1'b1;
  logic [7:0]  rxVal = '0;
  int          opCount = 0;
  logic [1:0]  opLog [32];
  logic        nakLog [32];
  logic [7:0]  byteLog [32];
  logic [31:0] r;

  always #10 clk = ~clk;

  i2c_cmd_seq dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wdata(wdata),
    .rdData(rdData), .engReq(engReq), .engOp(engOp), .engByte(engByte),
    .engNakLast(engNakLast), .engDone(engDone), .engAck(engAck),
    .engRxByte(engRxByte), .engBusy(engBusy), .irq(irq)
  );

  // Engine model: answers three cycles after a request, with a one-cycle done pulse.
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      if (engDone) engDone = 1'b0;
      else if (engReq) begin
        cnt++;
        if (cnt == 3) begin
          cnt = 0;
          engDone = 1'b1;
          engAck = ackVal;
          engRxByte = rxVal;
          if (opCount < 32) begin
            opLog[opCount] = engOp;
            nakLog[opCount] = engNakLast;
            byteLog[opCount] = engByte;
          end
          opCount++;
        end
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdData;
  endtask

  task automatic settle();
    repeat (40) @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  typedef struct packed {
    logic [7:0]  bufv;
    logic [5:0]  cmd;
    logic        ack;
    logic [7:0]  rx;
    logic [14:0] sts;
    logic [15:0] bufx;
    logic [3:0]  ph;
    logic [3:0]  ops;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{8'hA0, 6'h03, 1'b1, 8'h00, 15'h0001, 16'h00A0, 4'h8, 4'd1},
    '{8'h55, 6'h02, 1'b1, 8'h00, 15'h0001, 16'h0055, 4'h8, 4'd1},
    '{8'h33, 6'h02, 1'b0, 8'h00, 15'h0002, 16'h0033, 4'h8, 4'd1},
    '{8'hA1, 6'h01, 1'b1, 8'h00, 15'h0001, 16'h00A1, 4'h8, 4'd1},
    '{8'h00, 6'h08, 1'b1, 8'h5A, 15'h0004, 16'h5A00, 4'h8, 4'd1},
    '{8'h00, 6'h30, 1'b1, 8'hC3, 15'h0014, 16'hC300, 4'h0, 4'd2},
    '{8'h00, 6'h20, 1'b1, 8'h00, 15'h0020, 16'h0000, 4'h0, 4'd0},
    '{8'hA0, 6'h2B, 1'b1, 8'h77, 15'h0015, 16'h7700, 4'h0, 4'd3}
  };

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int base;
    doReset();
    // R1 reset state
    rd(6'h00, r); check("R1 ctrl", r, 32'h0);
    rd(6'h10, r); check("R1 status", r, 32'h0);
    rd(6'h14, r); check("R1 command", r, 32'h0);
    rd(6'h20, r); check("R1 buffer", r, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);

    // R2 masks
    wr(6'h00, 32'hFFFF_FFFF); rd(6'h00, r); check("R2 ctrl mask", r, 32'h0071_C3FF);
    wr(6'h04, 32'hFFFF_FFFF); rd(6'h04, r); check("R2 timing A mask", r, 32'h0FFF_FF0F);
    wr(6'h08, 32'hFFFF_FFFF); rd(6'h08, r); check("R2 timing B mask", r, 32'h7);
    wr(6'h0C, 32'hFFFF_FFFF); rd(6'h0C, r); check("R2 enable mask", r, 32'h7FFF);
    wr(6'h20, 32'h0000_1234); rd(6'h20, r); check("R2 buffer low byte", r, 32'h34);
    rd(6'h3C, r); check("R2 unmapped", r, 32'h0);
    doReset();

    // R3 disabled: command ignored
    wr(6'h20, 32'hA0);
    wr(6'h14, 32'h1);
    settle();
    check("R3 no op when disabled", opCount, 0);
    rd(6'h14, r); check("R3 command not stored", r, 32'h0);
    wr(6'h00, 32'h2);
    wr(6'h14, 32'hFFFF_0004);
    rd(6'h14, r); check("R3 slave enable stores low half", r, 32'h0004);
    doReset();

    // R11 busy readback
    engBusy = 1'b1; rd(6'h14, r); check("R11 busy bit set", r, 32'h0001_0000);
    engBusy = 1'b0; rd(6'h14, r); check("R11 busy bit clear", r, 32'h0);

    // Main table
    wr(6'h00, 32'h1);
    for (int i = 0; i < 8; i++) begin
      base = opCount;
      ackVal = VECS[i].ack;
      rxVal = VECS[i].rx;
      wr(6'h10, 32'h7FFF);
      wr(6'h20, {24'h0, VECS[i].bufv});
      wr(6'h14, {26'h0, VECS[i].cmd});
      settle();
      rd(6'h10, r); check($sformatf("R4 R5 R6 R7 status vec%0d", i), r, {17'h0, VECS[i].sts});
      rd(6'h20, r); check($sformatf("R6 buffer vec%0d", i), r, {16'h0, VECS[i].bufx});
      rd(6'h14, r); check($sformatf("R8 command vec%0d", i), r, {9'h0, VECS[i].ph, 19'h0});
      check($sformatf("R8 op count vec%0d", i), opCount - base, {28'h0, VECS[i].ops});
    end
    check("R4 begin op", {30'h0, opLog[0]}, 32'd0);
    check("R4 address byte", {24'h0, byteLog[0]}, 32'hA0);
    check("R5 send op", {30'h0, opLog[2]}, 32'd1);
    check("R5 send byte", {24'h0, byteLog[2]}, 32'h33);
    check("R6 receive no nak", {31'h0, nakLog[4]}, 32'd0);
    check("R6 receive-last nak", {31'h0, nakLog[5]}, 32'd1);
    check("R7 end op", {30'h0, opLog[6]}, 32'd3);
    check("R8 order begin", {30'h0, opLog[7]}, 32'd0);
    check("R8 order receive", {30'h0, opLog[8]}, 32'd2);
    check("R8 order end", {30'h0, opLog[9]}, 32'd3);

    // R4 phase codes during begin: 0x9 from idle, 0xA from active
    ackVal = 1'b1;
    wr(6'h20, 32'hA0);
    wr(6'h14, 32'h1);
    rd(6'h14, r); check("R4 begin code from idle", {28'h0, r[22:19]}, 32'h9);
    settle();
    wr(6'h14, 32'h1);
    rd(6'h14, r); check("R4 repeated begin code", {28'h0, r[22:19]}, 32'hA);
    settle();

    // R6 / R9 stalled receive restarts when its flag is cleared
    wr(6'h10, 32'h7FFF);
    rxVal = 8'h11;
    wr(6'h14, 32'h8);
    settle();
    rd(6'h20, r); check("R6 first receive", r, 32'h1100);
    base = opCount;
    rxVal = 8'h22;
    wr(6'h14, 32'h8);
    settle();
    check("R6 receive held while flag pending", opCount - base, 0);
    rd(6'h14, r); check("R6 receive stays pending", {16'h0, r[15:0]}, 32'h8);
    rd(6'h20, r); check("R6 buffer untouched", r, 32'h1100);
    wr(6'h10, 32'h4);
    settle();
    check("R9 receive restarted", opCount - base, 1);
    rd(6'h20, r); check("R9 restarted byte", r, 32'h2200);
    rd(6'h10, r); check("R9 flag set again", r, 32'h4);

    // R10 interrupt gating and latency
    check("R10 irq masked", {31'h0, irq}, 32'h0);
    wr(6'h0C, 32'h4);
    rd(6'h10, r);
    check("R10 irq raised", {31'h0, irq}, 32'h1);
    wr(6'h10, 32'h4);
    rd(6'h10, r);
    check("R10 irq dropped", {31'h0, irq}, 32'h0);

    // R9 partial clear and R7 normal end
    wr(6'h0C, 32'h0);
    wr(6'h14, 32'h20);
    settle();
    rd(6'h10, r); check("R7 normal end flag", r, 32'h10);
    rd(6'h14, r); check("R7 idle after end", r, 32'h0);
    wr(6'h14, 32'h20);
    settle();
    rd(6'h10, r); check("R7 abnormal end flag", r, 32'h30);
    wr(6'h10, 32'h8010);
    rd(6'h10, r); check("R9 partial clear", r, 32'h20);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule